// File: doc/BRIEF.md
# Signed Array Multiplier with Narrow-Bus Output Formatter

This block multiplies two two's complement operands and returns their signed product. Operand A is `A_W` bits and operand B is `B_W` bits, so the product is `A_W+B_W` bits wide. The array works on the signed operands directly. Every partial-product bit that pairs one sign bit with a non-sign bit is inverted. A correction constant with ones in bit positions `P-1`, `A_W-1` and `B_W-1` is then added to the array, where `P = A_W+B_W`. When `A_W = B_W = n`, this constant has ones at columns n and 2n-1. No sign fix-up is done before or after the array, and the multiply path between the operand and product points is purely combinational.

A format selector chooses how the product reaches a bus of half its width, `H = P/2`; `A_W+B_W` must be even. The selector can pass the whole product, keep only its upper half, keep the upper half after a one-bit left shift that drops the redundant second sign bit, or send the product as two half words on back-to-back cycles. The `REG_IO` parameter picks the variant. With `REG_IO = 1`, the operands and the output each get a register stage. With `REG_IO = 0`, the path from the operands to the result is combinational, and only the second half word of a split transfer is held in a register.

Top module: `bw_mult_top`

## Requirements
- R1: While `rst_ni` is low and on the first cycle after it is released, `valid_o` is 0 and `data_o` is 0.
- R2: The product is the signed value of `a_i` times `b_i`, `A_W+B_W` bits wide, and is exact for every operand pair, including most-negative times most-negative.
- R3: With `REG_IO = 1`, an input sampled at clock edge k is reflected on `data_o`/`valid_o` after edge k+1 and not earlier. With `REG_IO = 0`, it appears in the same cycle.
- R4: Format code 1 (keep upper half): `data_o[H-1:0]` holds product bits `[P-1:H]`, and the upper bits of `data_o` are 0.
- R5: Format code 2 (shift then keep upper half): `data_o[H-1:0]` holds product bits `[P-2:H-1]`, and the upper bits are 0. For most-negative times most-negative, this field wraps to the most negative half word.
- R6: Format code 3 (two words): the low half word (product bits `[H-1:0]`) comes out first with `valid_o` high. The high half word (bits `[P-1:H]`) follows on the very next cycle, also with `valid_o` high. The upper bits of `data_o` are 0 in both cycles.
- R7: An input presented in the cycle that carries the second half word of a two-word transfer is ignored and produces no output.
- R8: When no input is valid and no second half word is pending, the cycle delivers `valid_o` = 0 with `data_o` = 0.
- R9: Format code 0 (full): `data_o` is the whole `P`-bit product, with `valid_o` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands and format code are valid |
| a_i | input | A_W | Operand A, two's complement |
| b_i | input | B_W | Operand B, two's complement |
| fmt_i | input | 2 | Output format: 0 full, 1 upper half, 2 shifted upper half, 3 two words |
| valid_o | output | 1 | Output word valid |
| data_o | output | A_W+B_W | Product or half word (half word in low H bits) |

## Verification
For the 8x8 default, every one of the 65536 operand pairs is streamed in full format, one per cycle. This separates a correct Baugh-Wooley constant and correct inversion pattern from near misses that fail only when one or both sign bits are set. Random operands with random format codes and gaps in `valid_i` then show whether the truncation windows sit at the right bit offsets, and whether idle cycles stay quiet. Directed cases cover the extreme products (-128 x -128, 127 x -128, -1 x -1) in every format, and they confirm that the shifted truncation wraps only for -128 x -128. Two-word transfers are each followed by an input in the very next cycle, which separates correct low-then-high ordering, and discarding of the colliding input, from a design that swaps the halves or lets that input through.

// File: rtl/bw_mult_pkg.sv
package bw_mult_pkg;

  typedef enum logic [1:0] {
    FMT_FULL  = 2'd0,
    FMT_HI    = 2'd1,
    FMT_HI_SH = 2'd2,
    FMT_SPLIT = 2'd3
  } fmt_e;

endpackage

// File: rtl/bw_pp_array.sv
// Baugh-Wooley array: inverted mixed-sign terms plus correction constant.
module bw_pp_array #(
  parameter int A_W = 8,
  parameter int B_W = 8
) (
  input  logic [A_W-1:0]     a_i,
  input  logic [B_W-1:0]     b_i,
  output logic [A_W+B_W-1:0] prod_o
);

  localparam int P = A_W + B_W;
  localparam logic [P-1:0] ONE  = {{(P-1){1'b0}}, 1'b1};
  localparam logic [P-1:0] BW_K = (ONE << (P-1)) + (ONE << (A_W-1)) + (ONE << (B_W-1));

  logic [B_W-1:0][A_W-1:0] pp;
  logic [P-1:0]            row [B_W];
  logic [P-1:0]            acc [B_W+1];

  for (genvar j = 0; j < B_W; j++) begin : g_row
    for (genvar i = 0; i < A_W; i++) begin : g_bit
      localparam bit INV = (i == A_W-1) ^ (j == B_W-1);
      if (INV) begin : g_inv
        assign pp[j][i] = ~(a_i[i] & b_i[j]);
      end else begin : g_pos
        assign pp[j][i] = a_i[i] & b_i[j];
      end
    end
    assign row[j]   = {{B_W{1'b0}}, pp[j]} << j;
    assign acc[j+1] = acc[j] + row[j];
  end

  assign acc[0] = BW_K;
  assign prod_o = acc[B_W];

endmodule

// File: rtl/bw_fmt.sv
// Narrows the product for a half-width bus; holds the high half of a split.
module bw_fmt
  import bw_mult_pkg::*;
#(
  parameter int P = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  fmt_e         fmt_i,
  input  logic [P-1:0] prod_i,
  output logic [P-1:0] data_o,
  output logic         valid_o,
  output logic         busy_o
);

  localparam int H = P / 2;

  logic         pend_q, pend_d;
  logic [H-1:0] hi_q, hi_d;

  always_comb begin
    data_o  = '0;
    valid_o = 1'b0;
    pend_d  = 1'b0;
    hi_d    = hi_q;
    if (pend_q) begin
      data_o  = P'(hi_q);
      valid_o = 1'b1;
    end else if (valid_i) begin
      valid_o = 1'b1;
      unique case (fmt_i)
        FMT_FULL:  data_o = prod_i;
        FMT_HI:    data_o = P'(prod_i[P-1 -: H]);
        FMT_HI_SH: data_o = P'(prod_i[P-2 -: H]);
        FMT_SPLIT: begin
          data_o = P'(prod_i[H-1:0]);
          pend_d = 1'b1;
          hi_d   = prod_i[P-1 -: H];
        end
        default:   data_o = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      hi_q   <= '0;
    end else begin
      pend_q <= pend_d;
      hi_q   <= hi_d;
    end
  end

  assign busy_o = pend_q;

endmodule

// File: rtl/bw_mult_top.sv
module bw_mult_top
  import bw_mult_pkg::*;
#(
  parameter int A_W    = 8,
  parameter int B_W    = 8,
  parameter bit REG_IO = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [A_W-1:0]     a_i,
  input  logic [B_W-1:0]     b_i,
  input  logic [1:0]         fmt_i,
  output logic               valid_o,
  output logic [A_W+B_W-1:0] data_o
);

  localparam int P = A_W + B_W;

  logic           v_s;
  logic [A_W-1:0] a_s;
  logic [B_W-1:0] b_s;
  logic [1:0]     f_s;
  logic [P-1:0]   prod_w;
  logic [P-1:0]   data_c;
  logic           valid_c;
  logic           busy_w;

  if (REG_IO) begin : g_in_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_s <= 1'b0;
        a_s <= '0;
        b_s <= '0;
        f_s <= '0;
      end else begin
        v_s <= valid_i;
        a_s <= a_i;
        b_s <= b_i;
        f_s <= fmt_i;
      end
    end
  end else begin : g_in_comb
    assign v_s = valid_i;
    assign a_s = a_i;
    assign b_s = b_i;
    assign f_s = fmt_i;
  end

  bw_pp_array #(.A_W(A_W), .B_W(B_W)) i_array (
    .a_i    (a_s),
    .b_i    (b_s),
    .prod_o (prod_w)
  );

  bw_fmt #(.P(P)) i_fmt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (v_s),
    .fmt_i   (fmt_e'(f_s)),
    .prod_i  (prod_w),
    .data_o  (data_c),
    .valid_o (valid_c),
    .busy_o  (busy_w)
  );

  if (REG_IO) begin : g_out_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o <= 1'b0;
        data_o  <= '0;
      end else begin
        valid_o <= valid_c;
        data_o  <= data_c;
      end
    end
  end else begin : g_out_comb
    assign valid_o = valid_c;
    assign data_o  = data_c;
  end

endmodule

// File: rtl/bw_mult_chk.sv
module bw_mult_chk #(
  parameter int A_W    = 8,
  parameter int B_W    = 8,
  parameter bit REG_IO = 1'b1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               v_s,
  input logic [A_W-1:0]     a_s,
  input logic [B_W-1:0]     b_s,
  input logic [1:0]         f_s,
  input logic [A_W+B_W-1:0] prod_w,
  input logic               busy_w,
  input logic [A_W+B_W-1:0] data_c,
  input logic               valid_c,
  input logic [A_W+B_W-1:0] data_o,
  input logic               valid_o
);

  localparam int P = A_W + B_W;
  localparam int H = P / 2;

  logic signed [P-1:0] ref_p;
  logic                take;
  assign ref_p = $signed(a_s) * $signed(b_s);
  assign take  = v_s && !busy_w;

  AST_ARRAY_SIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prod_w == ref_p); // R2

  AST_FULL_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && f_s == 2'd0 |-> valid_c && data_c == ref_p); // R9

  AST_HI_TRUNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && f_s == 2'd1 |-> valid_c && data_c == P'(ref_p[P-1 -: H])); // R4

  AST_HI_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && f_s == 2'd2 |-> valid_c && data_c == P'(ref_p[P-2 -: H])); // R5

  AST_SPLIT_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && f_s == 2'd3 |-> valid_c && data_c == P'(ref_p[H-1:0])); // R6

  AST_SPLIT_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && f_s == 2'd3 |=> busy_w && valid_c && data_c == P'($past(ref_p[P-1 -: H]))); // R6

  AST_SPLIT_ONE_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_w |=> !busy_w); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !v_s && !busy_w |-> !valid_c && data_c == '0); // R8

  if (REG_IO) begin : g_lat_reg
    AST_OUT_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o == $past(valid_c) && data_o == $past(data_c)); // R3
  end else begin : g_lat_comb
    AST_OUT_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o == valid_c && data_o == data_c); // R3
  end

endmodule

bind bw_mult_top bw_mult_chk #(.A_W(A_W), .B_W(B_W), .REG_IO(REG_IO)) i_bw_mult_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .v_s     (v_s),
  .a_s     (a_s),
  .b_s     (b_s),
  .f_s     (f_s),
  .prod_w  (prod_w),
  .busy_w  (busy_w),
  .data_c  (data_c),
  .valid_c (valid_c),
  .data_o  (data_o),
  .valid_o (valid_o)
);

// File: tb/test_bw_mult_top.sv
module test_bw_mult_top;

  localparam int A_W = 8;
  localparam int B_W = 8;
  localparam int P   = A_W + B_W;

  logic           clk = 1'b0;
  logic           rst_ni = 1'b0;
  logic           valid_i = 1'b0;
  logic [A_W-1:0] a_i = '0;
  logic [B_W-1:0] b_i = '0;
  logic [1:0]     fmt_i = '0;
  logic           valid_o;
  logic [P-1:0]   data_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic           hv [2];
  logic [A_W-1:0] ha [2];
  logic [B_W-1:0] hb [2];
  logic [1:0]     hf [2];

  always #4 clk = ~clk;

  bw_mult_top #(.A_W(A_W), .B_W(B_W), .REG_IO(1'b1)) i_bw_mult_top (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .fmt_i   (fmt_i),
    .valid_o (valid_o),
    .data_o  (data_o)
  );

  function automatic logic [P-1:0] exp_word(logic [A_W-1:0] a, logic [B_W-1:0] b,
                                            logic [1:0] f, bit hi);
    logic signed [P-1:0] p;
    p = $signed(a) * $signed(b);
    case (f)
      2'd0:    return p;
      2'd1:    return {8'h00, p[15:8]};
      2'd2:    return {8'h00, p[14:7]};
      default: return hi ? {8'h00, p[15:8]} : {8'h00, p[7:0]};
    endcase
  endfunction

  task automatic check(string tag, logic got_v, logic exp_v, logic [P-1:0] got_d,
                       logic [P-1:0] exp_d);
    n_chk++;
    if (got_v !== exp_v || got_d !== exp_d) begin
      n_fail++;
      $display("FAIL %s: valid=%0b data=%h expected valid=%0b data=%h",
               tag, got_v, got_d, exp_v, exp_d);
    end
  endtask

  function automatic string fmt_tag(logic v, logic [1:0] f);
    if (!v) return "R8";
    case (f)
      2'd0:    return "R2 R9";
      2'd1:    return "R4";
      default: return "R5";
    endcase
  endfunction

  // One pipelined step: check the input driven two steps ago, then drive a new one.
  task automatic step(logic v, logic [A_W-1:0] a, logic [B_W-1:0] b, logic [1:0] f);
    @(negedge clk);
    if (hv[1]) check(fmt_tag(1'b1, hf[1]), valid_o, 1'b1, data_o, exp_word(ha[1], hb[1], hf[1], 1'b0));
    else       check("R8", valid_o, 1'b0, data_o, '0);
    hv[1] = hv[0]; ha[1] = ha[0]; hb[1] = hb[0]; hf[1] = hf[0];
    hv[0] = v;     ha[0] = a;     hb[0] = b;     hf[0] = f;
    valid_i = v; a_i = a; b_i = b; fmt_i = f;
  endtask

  task automatic flush();
    step(1'b0, '0, '0, 2'd0);
    step(1'b0, '0, '0, 2'd0);
    step(1'b0, '0, '0, 2'd0);
  endtask

  // Split transfer followed by a colliding input that must be ignored (R6, R7).
  task automatic split_case(logic [A_W-1:0] a, logic [B_W-1:0] b);
    @(negedge clk);
    valid_i = 1'b1; a_i = a; b_i = b; fmt_i = 2'd3;
    @(negedge clk);
    valid_i = 1'b1; a_i = 8'h7f; b_i = 8'h7f; fmt_i = 2'd0;
    @(negedge clk);
    valid_i = 1'b0;
    check("R6 low word", valid_o, 1'b1, data_o, exp_word(a, b, 2'd3, 1'b0));
    @(negedge clk);
    check("R6 high word", valid_o, 1'b1, data_o, exp_word(a, b, 2'd3, 1'b1));
    @(negedge clk);
    check("R7 ignored input", valid_o, 1'b0, data_o, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < 2; k++) begin
      hv[k] = 1'b0; ha[k] = '0; hb[k] = '0; hf[k] = '0;
    end
    repeat (3) @(negedge clk);
    check("R1 in reset", valid_o, 1'b0, data_o, '0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 after release", valid_o, 1'b0, data_o, '0);

    // R3: two-edge latency
    valid_i = 1'b1; a_i = 8'hfd; b_i = 8'h05; fmt_i = 2'd0;
    @(negedge clk);
    valid_i = 1'b0;
    check("R3 not yet", valid_o, 1'b0, data_o, '0);
    @(negedge clk);
    check("R3 arrives", valid_o, 1'b1, data_o, 16'hfff1);
    @(negedge clk);

    // R2 R9: every operand pair in full format
    for (int i = 0; i < 65536; i++) step(1'b1, i[15:8], i[7:0], 2'd0);
    flush();

    // Directed extremes in the single-word formats
    for (int f = 0; f < 3; f++) begin
      step(1'b1, 8'h80, 8'h80, f[1:0]);
      step(1'b1, 8'h7f, 8'h80, f[1:0]);
      step(1'b1, 8'hff, 8'hff, f[1:0]);
      step(1'b1, 8'h7f, 8'h7f, f[1:0]);
      step(1'b0, 8'h12, 8'h34, f[1:0]);
    end
    flush();
    // R5: shifted window wraps only for -128 x -128
    @(negedge clk);
    valid_i = 1'b1; a_i = 8'h80; b_i = 8'h80; fmt_i = 2'd2;
    @(negedge clk);
    valid_i = 1'b0;
    @(negedge clk);
    check("R5 wrap", valid_o, 1'b1, data_o, 16'h0080);

    // Random mix of formats and gaps
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[31:29] != 3'd0, r[7:0], r[15:8], (r[17:16] == 2'd3) ? 2'd1 : r[17:16]);
    end
    flush();

    // Two-word transfers
    split_case(8'h80, 8'h80);
    split_case(8'h7f, 8'h80);
    split_case(8'hff, 8'hff);
    split_case(8'h12, 8'hc3);
    for (int i = 0; i < 8; i++) begin
      logic [31:0] r;
      r = $urandom;
      split_case(r[7:0], r[15:8]);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule